// File: doc/BRIEF.md
# Byte-Wide Passive Configuration Loader

This block loads a programmable device through its byte-wide passive parallel configuration port. It runs from the host's system clock. A start pulse makes it drive the device's active-low configuration-reset line low for a set time and then release it. It then waits for the device's status line to rise, and holds off the first configuration clock edge until the device's minimum start-up delays have passed.

After that it takes bytes from a valid/ready source. It places each byte on the data pins while the configuration clock is low and raises the clock once the setup time has been met. The clock's high time, low time and period are set to the device limits for either the fast core mode or the slow, low-voltage core mode.

When the device raises its done line, the block finishes start-up in one of two ways. It can supply a user clock tail, or it can wait out the worst-case internal-oscillator start-up window. In both cases it then raises a user-mode flag. Every delay is a counter whose length is rounded up from a system-clock-period parameter given in picoseconds.

Top module: `pcfg_seq`

## Requirements
- R1: While reset is held, and after it is released, `cfg_rst_n` is high. `cfg_clk`, `usr_clk`, `s_ready`, `busy`, `user_mode` and all three error flags are low.
- R2: When idle, a `start` pulse drives `cfg_rst_n` low for exactly ceil(max(PULSE_PS, 1 µs) / CLK_PS) cycles and then drives it high again.
- R3: If `cfg_stat` has not risen within ceil(230 µs / CLK_PS) cycles of the release, `err_to` rises exactly that many cycles after the release. The block then returns to idle with no configuration clock edge.
- R4: The first rising edge of `cfg_clk` comes no sooner than ceil(230 µs / CLK_PS) cycles after the release of `cfg_rst_n`. It also comes no sooner than ceil(2 µs / CLK_PS) cycles after `cfg_stat` rises.
- R5: Each high phase of `cfg_clk` lasts at least ceil(tH / CLK_PS) cycles. Each low phase lasts at least the larger of that count and the setup count. The spacing between rising edges is at least ceil(tP / CLK_PS) cycles. With SLOW=0 the limits are tH=3.2 ns, setup=5 ns and tP=7.5 ns. With SLOW=1 they are tH=6.4 ns, setup=8 ns and tP=15 ns.
- R6: Each accepted byte appears on `cfg_data` while `cfg_clk` is low. It is held unchanged through the rising edge and the whole high phase. Bytes appear in acceptance order, with exactly one rising edge per byte. `s_ready` is high only while `cfg_clk` is low and no byte is waiting to be clocked.
- R7: If `cfg_stat` is low at any point after it first rises and before `cfg_done` is seen, the block sets `err_abort`, stops the clock low, takes no further bytes and returns to idle.
- R8: If MAX_BYTES bytes have been clocked and `cfg_done` is still low, the block sets `err_nodone`, takes no further bytes and returns to idle. If `cfg_done` is high at that point, the start-up phase is entered instead.
- R9: With `wake_uclk`=1 at start, the user clock begins no sooner than 4 configuration-clock periods after `cfg_done` is seen. `usr_clk` then gives exactly UCLK_N rising edges, each half-period one cycle long, and `user_mode` rises at the end.
- R10: With `wake_uclk`=0 at start, `user_mode` rises exactly ceil(650 µs / CLK_PS) cycles after the cycle in which `cfg_done` is seen, and `usr_clk` stays low.
- R11: `user_mode` and the error flags hold their values until the next accepted `start`, which clears them. At most one error flag is high at any time. A `start` while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run when idle |
| wake_uclk | input | 1 | Start-up choice sampled at start: 1 user clock tail, 0 oscillator wait |
| s_valid | input | 1 | Source byte valid |
| s_data | input | 8 | Source byte |
| s_ready | output | 1 | Block can take a byte this cycle |
| cfg_rst_n | output | 1 | Active-low configuration reset request to the device |
| cfg_stat | input | 1 | Device status, high when ready for data |
| cfg_done | input | 1 | Device reports configuration complete |
| cfg_clk | output | 1 | Configuration clock to the device |
| cfg_data | output | 8 | Configuration data byte to the device |
| usr_clk | output | 1 | Start-up user clock |
| busy | output | 1 | A run is in progress |
| user_mode | output | 1 | Start-up finished |
| err_to | output | 1 | Status did not rise in time |
| err_abort | output | 1 | Status fell during the run |
| err_nodone | output | 1 | Byte limit reached without done |

## Verification
The properties assume a well-behaved device. Once `cfg_stat` has risen, it stays high until the run is deliberately aborted. `cfg_done` rises only after bytes have been clocked. The source holds `s_data` steady while it waits for `s_ready`.

The bench models the device and the source with inputs that change only on the falling clock edge. The modelled device raises status a fixed 20 cycles after release, well inside the timeout. It drops status or raises done only right after a chosen byte's rising edge, so every abort and every done lands in a known phase of the clock. The bench sets the period parameter to 1 µs so that the long start-up waits become a few hundred cycles.

// File: rtl/pcfg_seq.sv
`timescale 1ns/1ps
module pcfg_seq #(
  parameter int CLK_PS    = 5000,
  parameter bit SLOW      = 1'b0,
  parameter int PULSE_PS  = 2_000_000,
  parameter int MAX_BYTES = 4096,
  parameter int UCLK_N    = 3192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wake_uclk,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  output logic       s_ready,
  output logic       cfg_rst_n,
  input  logic       cfg_stat,
  input  logic       cfg_done,
  output logic       cfg_clk,
  output logic [7:0] cfg_data,
  output logic       usr_clk,
  output logic       busy,
  output logic       user_mode,
  output logic       err_to,
  output logic       err_abort,
  output logic       err_nodone
);

  function automatic int cdiv(int t);
    return (t + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_SU   = SLOW ? 8000 : 5000;
  localparam int T_HL   = SLOW ? 6400 : 3200;
  localparam int T_PER  = SLOW ? 15000 : 7500;
  localparam int C_HI   = imax(cdiv(T_HL), 1);
  localparam int C_LO0  = imax(imax(cdiv(T_SU), cdiv(T_HL)), 1);
  localparam int C_LO   = imax(C_LO0, cdiv(T_PER) - C_HI);
  localparam int C_RST  = cdiv(imax(PULSE_PS, 1_000_000));
  localparam int C_STTO = cdiv(230_000_000);
  localparam int C_CF2K = cdiv(230_000_000);
  localparam int C_ST2K = cdiv(2_000_000);
  localparam int C_CU   = 4 * (C_HI + C_LO);
  localparam int C_UM   = cdiv(650_000_000);
  localparam int C_TOP  = imax(imax(imax(C_UM, C_RST), imax(C_CU, UCLK_N)),
                               imax(imax(C_STTO, C_CF2K), imax(C_ST2K, C_LO + C_HI)));
  localparam int CW     = $clog2(C_TOP + 2);
  localparam int BW     = $clog2(MAX_BYTES + 1);

  typedef enum logic [3:0] {
    IDLE, PULSE, WSTAT, PRE, LOW, HIGH, CUWAIT, UCLKS, OSCW
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt, rel;
  logic [BW-1:0]  nb;
  logic           have, mode_u;
  logic           rst_q, clk_q, uclk_q, um_q, e_to, e_ab, e_nd;
  logic [7:0]     dat_q;

  assign s_ready    = (st == LOW) && !have && cfg_stat && !cfg_done &&
                      (nb != BW'(MAX_BYTES));
  assign busy       = (st != IDLE);
  assign cfg_rst_n  = rst_q;
  assign cfg_clk    = clk_q;
  assign cfg_data   = dat_q;
  assign usr_clk    = uclk_q;
  assign user_mode  = um_q;
  assign err_to     = e_to;
  assign err_abort  = e_ab;
  assign err_nodone = e_nd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      rel    <= '0;
      nb     <= '0;
      have   <= 1'b0;
      mode_u <= 1'b0;
      rst_q  <= 1'b1;
      clk_q  <= 1'b0;
      dat_q  <= '0;
      uclk_q <= 1'b0;
      um_q   <= 1'b0;
      e_to   <= 1'b0;
      e_ab   <= 1'b0;
      e_nd   <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st     <= PULSE;
          rst_q  <= 1'b0;
          cnt    <= '0;
          mode_u <= wake_uclk;
          um_q   <= 1'b0;
          e_to   <= 1'b0;
          e_ab   <= 1'b0;
          e_nd   <= 1'b0;
        end
        PULSE: if (cnt == CW'(C_RST - 1)) begin
          rst_q <= 1'b1;
          st    <= WSTAT;
          cnt   <= '0;
          rel   <= '0;
        end else cnt <= cnt + CW'(1);
        WSTAT: if (cfg_stat) begin
          st  <= PRE;
          cnt <= '0;
          rel <= rel + CW'(1);
        end else if (rel == CW'(C_STTO - 1)) begin
          e_to <= 1'b1;
          st   <= IDLE;
        end else rel <= rel + CW'(1);
        PRE: if (!cfg_stat) begin
          e_ab <= 1'b1;
          st   <= IDLE;
        end else begin
          if (rel < CW'(C_CF2K)) rel <= rel + CW'(1);
          if (cnt < CW'(C_ST2K)) cnt <= cnt + CW'(1);
          if (rel >= CW'(C_CF2K) && cnt >= CW'(C_ST2K)) begin
            st   <= LOW;
            cnt  <= '0;
            nb   <= '0;
            have <= 1'b0;
          end
        end
        LOW: if (!cfg_stat) begin
          e_ab <= 1'b1;
          have <= 1'b0;
          st   <= IDLE;
        end else if (!have) begin
          if (cfg_done) begin
            st  <= mode_u ? CUWAIT : OSCW;
            cnt <= '0;
          end else if (nb == BW'(MAX_BYTES)) begin
            e_nd <= 1'b1;
            st   <= IDLE;
          end else if (s_valid) begin
            dat_q <= s_data;
            have  <= 1'b1;
            cnt   <= '0;
          end
        end else if (cnt == CW'(C_LO - 1)) begin
          clk_q <= 1'b1;
          st    <= HIGH;
          cnt   <= '0;
        end else cnt <= cnt + CW'(1);
        HIGH: if (!cfg_stat) begin
          e_ab  <= 1'b1;
          clk_q <= 1'b0;
          have  <= 1'b0;
          st    <= IDLE;
        end else if (cnt == CW'(C_HI - 1)) begin
          clk_q <= 1'b0;
          have  <= 1'b0;
          nb    <= nb + BW'(1);
          st    <= LOW;
          cnt   <= '0;
        end else cnt <= cnt + CW'(1);
        CUWAIT: if (cnt == CW'(C_CU - 1)) begin
          st  <= UCLKS;
          cnt <= '0;
        end else cnt <= cnt + CW'(1);
        UCLKS: if (!uclk_q) uclk_q <= 1'b1;
        else begin
          uclk_q <= 1'b0;
          if (cnt == CW'(UCLK_N - 1)) begin
            um_q <= 1'b1;
            st   <= IDLE;
          end else cnt <= cnt + CW'(1);
        end
        OSCW: if (cnt == CW'(C_UM - 1)) begin
          um_q <= 1'b1;
          st   <= IDLE;
        end else cnt <= cnt + CW'(1);
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pcfg_seq_chk.sv
`timescale 1ns/1ps
module pcfg_seq_chk #(
  parameter int CLK_PS   = 5000,
  parameter bit SLOW     = 1'b0,
  parameter int PULSE_PS = 2_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rst_n,
  input logic       cfg_clk,
  input logic [7:0] cfg_data,
  input logic       s_ready,
  input logic       err_to,
  input logic       err_abort,
  input logic       err_nodone
);

  function automatic int cdiv(int t);
    return (t + CLK_PS - 1) / CLK_PS;
  endfunction

  localparam int LIM   = 1 << 30;
  localparam int K_RST = cdiv((PULSE_PS > 1_000_000) ? PULSE_PS : 1_000_000);
  localparam int K_HI  = cdiv(SLOW ? 6400 : 3200);
  localparam int K_SU  = cdiv(SLOW ? 8000 : 5000);
  localparam int K_LO  = (K_SU > K_HI) ? K_SU : K_HI;
  localparam int K_PER = cdiv(SLOW ? 15000 : 7500);
  localparam int K_CF  = cdiv(230_000_000);

  int   lo_rst, hi_n, lo_n, per_n, since_rel;
  logic clk_p, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_rst    <= 0;
      hi_n      <= 0;
      lo_n      <= LIM;
      per_n     <= LIM;
      since_rel <= 0;
      clk_p     <= 1'b0;
      pend      <= 1'b0;
    end else begin
      lo_rst    <= cfg_rst_n ? 0 : ((lo_rst < LIM) ? lo_rst + 1 : lo_rst);
      hi_n      <= cfg_clk ? hi_n + 1 : 0;
      lo_n      <= cfg_clk ? 0 : ((lo_n < LIM) ? lo_n + 1 : lo_n);
      per_n     <= (cfg_clk && !clk_p) ? 1 : ((per_n < LIM) ? per_n + 1 : per_n);
      since_rel <= !cfg_rst_n ? 0 : ((since_rel < LIM) ? since_rel + 1 : since_rel);
      clk_p     <= cfg_clk;
      if (!cfg_rst_n) pend <= 1'b1;
      else if (cfg_clk) pend <= 1'b0;
    end
  end

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rst_n) |-> lo_rst >= K_RST);

  // R4
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_clk) && pend) |-> since_rel >= K_CF);

  // R5
  high_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_clk) |-> hi_n >= K_HI);

  // R5
  low_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> (lo_n >= K_LO && per_n >= K_PER));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> $stable(cfg_data));

  // R6
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cfg_clk);

  // R11
  one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_to, err_abort, err_nodone}));

endmodule

bind pcfg_seq pcfg_seq_chk #(.CLK_PS(CLK_PS), .SLOW(SLOW), .PULSE_PS(PULSE_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rst_n(cfg_rst_n), .cfg_clk(cfg_clk),
  .cfg_data(cfg_data), .s_ready(s_ready), .err_to(err_to),
  .err_abort(err_abort), .err_nodone(err_nodone)
);

// File: tb/pcfg_seq_test.sv
`timescale 1ns/1ps
module pcfg_seq_test;
  localparam int E_RST = 3, E_TO = 230, E_CF = 230, E_ST = 2, E_CU = 8;
  localparam int E_UM = 650, E_PER = 2, UN = 3192, MAXB = 8;

  // {wake, nostat, done_at[3:0], drop_at[3:0], code[1:0], nrx[3:0]}
  // code: 0 user mode, 1 timeout, 2 abort, 3 no done
  localparam logic [15:0] VEC [6] = '{
    {1'b1, 1'b0, 4'd6, 4'd0, 2'd0, 4'd6},
    {1'b0, 1'b0, 4'd3, 4'd0, 2'd0, 4'd3},
    {1'b0, 1'b1, 4'd0, 4'd0, 2'd1, 4'd0},
    {1'b1, 1'b0, 4'd0, 4'd4, 2'd2, 4'd4},
    {1'b0, 1'b0, 4'd8, 4'd0, 2'd0, 4'd8},
    {1'b0, 1'b0, 4'd0, 4'd0, 2'd3, 4'd8}
  };

  logic clk = 0, rst_n = 0, start = 0, wake_uclk = 0, s_valid = 0;
  logic [7:0] s_data = 0;
  logic cfg_stat = 0, cfg_done = 0;
  logic s_ready, cfg_rst_n, cfg_clk, usr_clk, busy, user_mode;
  logic err_to, err_abort, err_nodone;
  logic [7:0] cfg_data;

  pcfg_seq #(.CLK_PS(1_000_000), .SLOW(1'b0), .PULSE_PS(3_000_000),
             .MAX_BYTES(MAXB), .UCLK_N(UN)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wake_uclk(wake_uclk),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cfg_rst_n(cfg_rst_n), .cfg_stat(cfg_stat), .cfg_done(cfg_done),
    .cfg_clk(cfg_clk), .cfg_data(cfg_data), .usr_clk(usr_clk), .busy(busy),
    .user_mode(user_mode), .err_to(err_to), .err_abort(err_abort),
    .err_nodone(err_nodone));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int v, int i);
    return 8'(v * 17 + i * 29 + 3);
  endfunction

  int vsel = 0, done_at = 0, drop_at = 0;
  bit nostat = 0, dropped = 0, hs = 0;
  int cyc = 0, idx = 0, nrx = 0, nbad_data = 0, n_fall = 0;
  int fall_cyc = 0, rel_cyc = -1, pulse_len = 0, st_cyc = -1, first_rise = -1;
  int last_rise = 0, min_per = 1 << 30, done_cyc = -1, um_cyc = -1, to_cyc = -1;
  int usr_first = -1, usr_rises = 0;
  logic p_rst = 1, p_clk = 0, p_usr = 0, p_um = 0, p_to = 0;

  always @(negedge clk) begin
    cyc++;
    if (p_rst && !cfg_rst_n) begin
      fall_cyc = cyc; n_fall++; cfg_stat = 0; cfg_done = 0; dropped = 0;
      idx = 0; hs = 0; nrx = 0; nbad_data = 0; rel_cyc = -1; st_cyc = -1;
      first_rise = -1; min_per = 1 << 30; done_cyc = -1; um_cyc = -1;
      to_cyc = -1; usr_first = -1; usr_rises = 0;
    end
    if (!p_rst && cfg_rst_n) begin rel_cyc = cyc; pulse_len = cyc - fall_cyc; end
    if (hs) idx++;
    s_data = exp_byte(vsel, idx);
    if (cfg_rst_n && rel_cyc >= 0 && !nostat && !dropped && cyc == rel_cyc + 20) begin
      cfg_stat = 1; st_cyc = cyc;
    end
    if (!p_clk && cfg_clk) begin
      if (first_rise < 0) first_rise = cyc;
      else if (cyc - last_rise < min_per) min_per = cyc - last_rise;
      last_rise = cyc;
      if (cfg_data != exp_byte(vsel, nrx)) nbad_data++;
      nrx++;
      if (nrx == drop_at) begin cfg_stat = 0; dropped = 1; end
      if (nrx == done_at) begin cfg_done = 1; done_cyc = cyc; end
    end
    if (!p_usr && usr_clk) begin if (usr_first < 0) usr_first = cyc; usr_rises++; end
    if (!p_um && user_mode) um_cyc = cyc;
    if (!p_to && err_to) to_cyc = cyc;
    p_rst = cfg_rst_n; p_clk = cfg_clk; p_usr = usr_clk; p_um = user_mode; p_to = err_to;
    #2;
    hs = s_valid && s_ready;
  end

  task automatic run_once();
    @(negedge clk) start = 1; s_valid = 1;
    @(negedge clk) start = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    s_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state while held and after release
    chk(cfg_rst_n == 1 && cfg_clk == 0 && usr_clk == 0, "R1", "pins in reset", 0, 0);
    chk(s_ready == 0 && busy == 0 && user_mode == 0, "R1", "status in reset", 0, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({err_to, err_abort, err_nodone} == 3'b000, "R1", "error flags", int'({err_to, err_abort, err_nodone}), 0);
    chk(cfg_rst_n == 1 && busy == 0 && s_ready == 0, "R1", "idle after reset", 0, 0);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] code;
      int enrx;
      wake_uclk = VEC[v][15]; nostat = VEC[v][14];
      done_at = int'(VEC[v][13:10]); drop_at = int'(VEC[v][9:6]);
      code = VEC[v][5:4]; enrx = int'(VEC[v][3:0]); vsel = v;
      run_once();
      chk(pulse_len == E_RST, "R2", "reset pulse length", pulse_len, E_RST);
      chk(err_to == (code == 2'd1), "R3", "timeout flag", int'(err_to), int'(code == 2'd1));
      chk(err_abort == (code == 2'd2), "R7", "abort flag", int'(err_abort), int'(code == 2'd2));
      chk(err_nodone == (code == 2'd3), "R8", "no-done flag", int'(err_nodone), int'(code == 2'd3));
      chk(user_mode == (code == 2'd0), "R9", "user mode flag", int'(user_mode), int'(code == 2'd0));
      chk(nrx == enrx, "R6", "bytes clocked", nrx, enrx);
      chk(nbad_data == 0, "R6", "byte mismatches", nbad_data, 0);
      if (code == 2'd1)
        chk(to_cyc - rel_cyc == E_TO, "R3", "timeout delay", to_cyc - rel_cyc, E_TO);
      if (enrx > 0) begin
        chk(first_rise - rel_cyc >= E_CF, "R4", "release to first edge", first_rise - rel_cyc, E_CF);
        chk(first_rise - st_cyc >= E_ST, "R4", "status to first edge", first_rise - st_cyc, E_ST);
      end
      if (enrx > 1)
        chk(min_per >= E_PER, "R5", "clock period", min_per, E_PER);
      if (code == 2'd0 && wake_uclk) begin
        chk(usr_rises == UN, "R9", "user clock edges", usr_rises, UN);
        chk(usr_first - done_cyc >= E_CU, "R9", "done to user clock", usr_first - done_cyc, E_CU);
      end else
        chk(usr_rises == 0, "R10", "user clock silent", usr_rises, 0);
      if (code == 2'd0 && !wake_uclk)
        chk(um_cyc - done_cyc >= E_UM && um_cyc - done_cyc <= E_UM + 4,
            "R10", "done to user mode", um_cyc - done_cyc, E_UM);
      if (code == 2'd2)
        chk(cfg_clk == 0 && s_ready == 0, "R7", "clock parked low", int'(cfg_clk), 0);
    end

    // R11 sticky flag, cleared by next start, repeated start ignored
    repeat (20) @(negedge clk);
    chk(err_nodone == 1, "R11", "flag held while idle", int'(err_nodone), 1);
    begin
      int falls0;
      falls0 = n_fall;
      nostat = 1; vsel = 7;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      chk(err_nodone == 0, "R11", "flag cleared by start", int'(err_nodone), 0);
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(n_fall - falls0 == 1, "R11", "reset pulses in run", n_fall - falls0, 1);
      chk(err_to == 1, "R3", "timeout after ignored start", int'(err_to), 1);
      chk(to_cyc - rel_cyc == E_TO, "R3", "timeout delay", to_cyc - rel_cyc, E_TO);
    end

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule